// File: doc/BRIEF.md
# Asymmetric Karatsuba Polynomial Multiplier

This block multiplies two polynomials of length 2n with small signed integer coefficients and returns all 4n−1 coefficients of their exact product. Each operand is split into a low half and a high half of n coefficients. One Karatsuba level then replaces the four half-size products with three. The cross product is formed from two differences whose subtraction orders are opposite: low minus high on the first operand, high minus low on the second. Because of this, the cross term is added in the combine step instead of being subtracted.

A single multiply-accumulate unit computes the three n×n half products, one coefficient pair per cycle. It handles the low-by-low product, then the high-by-high product, then the difference-by-difference product. A combine network then builds the result. It first forms one shared partial sum (the upper part of the low product plus the lower part of the high product). The two middle quarters of the result are built from that shared sum. The operand vectors enter through a valid/ready handshake and the result leaves through another.

Back-pressure rules: an operand pair is taken on a rising edge where `in_valid` and `in_ready` are both high. `in_ready` is low for the whole computation. Once a result is waiting, `in_ready` follows `out_ready`. The result stays on `out_p` with `out_valid` high until a rising edge sees `out_ready` high. A new operand pair may be taken on that same edge.

Top module: `kara_polymul`

## Requirements
- R1: Output coefficient k equals the sum of a_i·b_j over all i+j=k, for any pair of operand vectors with signed 15-bit coefficients.
- R2: Input coefficient k sits at bits [k·15 +: 15] of `in_a` and of `in_b`, in two's complement. Output coefficient k sits at bits [k·37 +: 37] of `out_p`, in two's complement.
- R3: The result does not wrap for extreme operands. Examples are all coefficients at +16383, all at −16384, mixed extremes, and operands whose half differences reach ±32767. For instance, all −16384 times all −16384 gives 12·2^28 at coefficient 11.
- R4: `out_valid` rises on the 3n²+1-th rising edge after the edge that takes the operands. With n = 6 this is the 109th edge.
- R5: Each accepted operand pair gives exactly one result transfer. While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_p` does not change.
- R6: `in_ready` is high when no work is pending. It is low while a computation runs. While a result waits, `in_ready` equals `out_ready`.
- R7: A new operand pair can be taken on the same edge that hands off a result. The new result is correct and arrives with the latency of R4.
- R8: After reset, asserted at any time, `out_valid` is low and `in_ready` is high, and the next computation is correct.
- R9: Changes on `in_a` and `in_b` while a computation runs do not affect its result.
- R10: A coefficient with no nonzero contributing pair comes out zero, including right after a run with large values. Single-term operands X^p and X^q give 1 at coefficient p+q only, up to the top coefficient 4n−2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Block can take an operand pair |
| in_a | input | 2n·15 (180) | First operand coefficients, packed |
| in_b | input | 2n·15 (180) | Second operand coefficients, packed |
| out_valid | output | 1 | Product result held on out_p |
| out_ready | input | 1 | Consumer takes the result |
| out_p | output | (4n−1)·37 (851) | Product coefficients, packed |

## Verification
Two actions can fall on the same rising edge: the handoff of a finished product and the acceptance of the next operand pair. The bench provokes this by raising `out_ready` and `in_valid` together while a result waits, with a different operand pair on the inputs. The handoff is judged correct if `out_valid` drops, `in_ready` drops and stays low, and the second product arrives exactly 3n²+1 edges later with every coefficient matching an independent convolution. Stale accumulator contents are probed separately by running a single-term product right after an all-minimum one.

// File: rtl/kara_pkg.sv
package kara_pkg;

  // Control states of the sequencer
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_COMB = 2'd2,
    ST_HOLD = 2'd3
  } kara_state_t;

  // Which half product the engine is working on (also the bank index)
  typedef enum logic [1:0] {
    PS_LO = 2'd0,  // low half times low half
    PS_HI = 2'd1,  // high half times high half
    PS_X  = 2'd2   // difference times difference
  } kara_part_t;

endpackage

// File: rtl/kara_split.sv
module kara_split #(
  parameter int HALF_N = 6,
  parameter int CW     = 15,
  localparam int FULL_N = 2 * HALF_N,
  localparam int OW     = CW + 1
) (
  input  logic [FULL_N*CW-1:0]   a_flat,
  input  logic [FULL_N*CW-1:0]   b_flat,
  output logic [3*HALF_N*OW-1:0] a_parts,
  output logic [3*HALF_N*OW-1:0] b_parts
);
  // Part blocks: [0] low half, [1] high half, [2] difference.
  // First operand difference is low minus high; second is high minus low.
  for (genvar k = 0; k < HALF_N; k++) begin : g_coef
    logic signed [OW-1:0] a_lo, a_hi, b_lo, b_hi;
    assign a_lo = OW'($signed(a_flat[k*CW +: CW]));
    assign a_hi = OW'($signed(a_flat[(HALF_N+k)*CW +: CW]));
    assign b_lo = OW'($signed(b_flat[k*CW +: CW]));
    assign b_hi = OW'($signed(b_flat[(HALF_N+k)*CW +: CW]));

    assign a_parts[k*OW +: OW]            = a_lo;
    assign a_parts[(HALF_N+k)*OW +: OW]   = a_hi;
    assign a_parts[(2*HALF_N+k)*OW +: OW] = a_lo - a_hi;

    assign b_parts[k*OW +: OW]            = b_lo;
    assign b_parts[(HALF_N+k)*OW +: OW]   = b_hi;
    assign b_parts[(2*HALF_N+k)*OW +: OW] = b_hi - b_lo;
  end
endmodule

// File: rtl/kara_mac.sv
module kara_mac
  import kara_pkg::*;
#(
  parameter int HALF_N = 6,
  parameter int OW     = 16,
  parameter int PW     = 37,
  localparam int HALF_P = 2 * HALF_N - 1,
  localparam int IDXW   = $clog2(HALF_P + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr,
  input  logic                     en,
  input  kara_part_t               part,
  input  logic [IDXW-1:0]          idx,
  input  logic signed [OW-1:0]     a_op,
  input  logic signed [OW-1:0]     b_op,
  output logic [3*HALF_P*PW-1:0]   banks
);
  logic signed [PW-1:0] mul;
  assign mul = PW'(a_op) * PW'(b_op);

  // One accumulator per coefficient of each half product
  for (genvar bk = 0; bk < 3; bk++) begin : g_bank
    for (genvar c = 0; c < HALF_P; c++) begin : g_acc
      logic signed [PW-1:0] acc;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          acc <= '0;
        end else if (clr) begin
          acc <= '0;
        end else if (en && (int'(part) == bk) && (idx == IDXW'(c))) begin
          acc <= acc + mul;
        end
      end
      assign banks[(bk*HALF_P + c)*PW +: PW] = acc;
    end
  end
endmodule

// File: rtl/kara_combine.sv
module kara_combine #(
  parameter int HALF_N = 6,
  parameter int PW     = 37,
  localparam int HALF_P = 2 * HALF_N - 1,
  localparam int OUT_N  = 4 * HALF_N - 1
) (
  input  logic [3*HALF_P*PW-1:0] banks,
  output logic [OUT_N*PW-1:0]    prod
);
  for (genvar k = 0; k < HALF_N; k++) begin : g_col
    logic signed [PW-1:0] u_lo, u_hi, v_lo, v_hi, w_lo, w_hi;
    logic signed [PW-1:0] shared, mid_lo, mid_hi;

    assign u_lo = banks[(0*HALF_P + k)*PW +: PW];
    assign v_lo = banks[(1*HALF_P + k)*PW +: PW];
    assign w_lo = banks[(2*HALF_P + k)*PW +: PW];

    if (k < HALF_N - 1) begin : g_upper
      assign u_hi = banks[(0*HALF_P + HALF_N + k)*PW +: PW];
      assign v_hi = banks[(1*HALF_P + HALF_N + k)*PW +: PW];
      assign w_hi = banks[(2*HALF_P + HALF_N + k)*PW +: PW];
      assign prod[(3*HALF_N + k)*PW +: PW] = v_hi;
    end else begin : g_top
      assign u_hi = '0;
      assign v_hi = '0;
      assign w_hi = '0;
    end

    // One shared partial feeds both middle quarters
    assign shared = u_hi + v_lo;
    assign mid_lo = shared + u_lo;
    assign mid_hi = shared + v_hi;

    assign prod[k*PW +: PW]              = u_lo;
    assign prod[(HALF_N + k)*PW +: PW]   = mid_lo + w_lo;
    assign prod[(2*HALF_N + k)*PW +: PW] = mid_hi + w_hi;
  end
endmodule

// File: rtl/kara_polymul.sv
module kara_polymul
  import kara_pkg::*;
#(
  parameter int HALF_N = 6,
  parameter int CW     = 15,
  localparam int FULL_N = 2 * HALF_N,
  localparam int OUT_N  = 4 * HALF_N - 1,
  localparam int HALF_P = 2 * HALF_N - 1,
  localparam int OW     = CW + 1,
  localparam int PW     = 2 * OW + $clog2(HALF_N) + 2,
  localparam int CNTW   = $clog2(HALF_N + 1),
  localparam int IDXW   = $clog2(HALF_P + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [FULL_N*CW-1:0]    in_a,
  input  logic [FULL_N*CW-1:0]    in_b,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [OUT_N*PW-1:0]     out_p
);
  localparam logic [CNTW-1:0] LAST = CNTW'(HALF_N - 1);

  kara_state_t             state;
  kara_part_t              part_q;
  logic [CNTW-1:0]         i_q, j_q;
  logic [3*HALF_N*OW-1:0]  split_a, split_b, lat_a, lat_b;
  logic signed [OW-1:0]    a_op, b_op;
  logic [IDXW-1:0]         idx;
  logic [3*HALF_P*PW-1:0]  banks;
  logic [OUT_N*PW-1:0]     comb_p, out_q;
  logic                    accept, run, last;

  assign in_ready  = (state == ST_IDLE) || ((state == ST_HOLD) && out_ready);
  assign accept    = in_valid && in_ready;
  assign run       = (state == ST_RUN);
  assign last      = (part_q == PS_X) && (i_q == LAST) && (j_q == LAST);
  assign out_valid = (state == ST_HOLD);
  assign out_p     = out_q;

  kara_split #(.HALF_N(HALF_N), .CW(CW)) split_i (
    .a_flat (in_a),
    .b_flat (in_b),
    .a_parts(split_a),
    .b_parts(split_b)
  );

  assign a_op = lat_a[(int'(part_q)*HALF_N + int'(i_q))*OW +: OW];
  assign b_op = lat_b[(int'(part_q)*HALF_N + int'(j_q))*OW +: OW];
  assign idx  = IDXW'(i_q) + IDXW'(j_q);

  kara_mac #(.HALF_N(HALF_N), .OW(OW), .PW(PW)) mac_i (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (accept),
    .en   (run),
    .part (part_q),
    .idx  (idx),
    .a_op (a_op),
    .b_op (b_op),
    .banks(banks)
  );

  kara_combine #(.HALF_N(HALF_N), .PW(PW)) comb_i (
    .banks(banks),
    .prod (comb_p)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      part_q <= PS_LO;
      i_q    <= '0;
      j_q    <= '0;
      lat_a  <= '0;
      lat_b  <= '0;
      out_q  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept) state <= ST_RUN;
        ST_RUN:  if (last) state <= ST_COMB;
        ST_COMB: state <= ST_HOLD;
        ST_HOLD: if (out_ready) state <= in_valid ? ST_RUN : ST_IDLE;
        default: state <= ST_IDLE;
      endcase

      if (accept) begin
        lat_a  <= split_a;
        lat_b  <= split_b;
        part_q <= PS_LO;
        i_q    <= '0;
        j_q    <= '0;
      end else if (run) begin
        if (j_q == LAST) begin
          j_q <= '0;
          if (i_q == LAST) begin
            i_q <= '0;
            unique case (part_q)
              PS_LO:   part_q <= PS_HI;
              PS_HI:   part_q <= PS_X;
              default: part_q <= PS_LO;
            endcase
          end else begin
            i_q <= i_q + 1'b1;
          end
        end else begin
          j_q <= j_q + 1'b1;
        end
      end

      if (state == ST_COMB) out_q <= comb_p;
    end
  end
endmodule

// File: rtl/kara_polymul_chk.sv
module kara_polymul_chk #(
  parameter int HALF_N = 6,
  parameter int CW     = 15,
  localparam int OUT_N = 4 * HALF_N - 1,
  localparam int OW    = CW + 1,
  localparam int PW    = 2 * OW + $clog2(HALF_N) + 2,
  localparam int EXPC  = 3 * HALF_N * HALF_N + 2,
  localparam int CNT_W = $clog2(EXPC + 2) + 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic               in_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic [OUT_N*PW-1:0] out_p
);
  // Cycle counter started by an accepted operand pair, cleared by a handoff
  logic [CNT_W-1:0] cnt;
  logic accept;
  assign accept = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (accept) cnt <= CNT_W'(1);
    else if (out_valid && out_ready) cnt <= '0;
    else if ((cnt != '0) && !out_valid) cnt <= cnt + 1'b1;
  end

  assert_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> (cnt == CNT_W'(EXPC)));

  assert_hold_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);

  assert_hold_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_p));

  assert_busy_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt != '0) && !out_valid) |-> !in_ready);

  assert_idle_open_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt == '0) && !out_valid) |-> in_ready);

  assert_same_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |-> in_ready);
endmodule

bind kara_polymul kara_polymul_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_p    (out_p)
);

// File: tb/kara_polymul_tb_top.sv
module kara_polymul_tb_top;
  localparam int N   = 6;
  localparam int CW  = 15;
  localparam int FN  = 2 * N;
  localparam int ON  = 4 * N - 1;
  localparam int OW  = CW + 1;
  localparam int PW  = 2 * OW + $clog2(N) + 2;
  localparam int LAT = 3 * N * N + 1;

  // Stimulus table: mode/seed per operand. Modes: 0 pseudo-random,
  // 1 all +16383, 2 all -16384, 3 single term X^seed,
  // 4 alternating extremes, 5 low +max/high -min, 6 low -min/high +max.
  localparam int NV = 10;
  localparam int TM_A [NV] = '{0, 0, 1, 2, 3, 1, 5, 3, 0, 4};
  localparam int TS_A [NV] = '{1, 5, 0, 0, 0, 0, 0, 11, 9, 0};
  localparam int TM_B [NV] = '{0, 0, 1, 2, 3, 2, 6, 3, 3, 5};
  localparam int TS_B [NV] = '{2, 6, 0, 0, 0, 0, 0, 11, 4, 0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b0;
  logic [FN*CW-1:0] in_a = '0;
  logic [FN*CW-1:0] in_b = '0;
  logic in_ready, out_valid;
  logic [ON*PW-1:0] out_p;

  always #10 clk = ~clk;

  kara_polymul #(.HALF_N(N), .CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
    .out_p(out_p)
  );

  int n_run = 0;
  int n_fail = 0;
  int ca [FN];
  int cb [FN];
  longint ex [ON];

  function automatic int gen(int mode, int seed, int k);
    logic [31:0] h;
    case (mode)
      0: begin
        h = (32'(seed) * 32'd977 + 32'(k) * 32'd7919 + 32'd13) * 32'h9E3779B1;
        h = h ^ (h >> 15);
        return int'($signed(h[14:0]));
      end
      1: return 16383;
      2: return -16384;
      3: return (k == seed) ? 1 : 0;
      4: return (k % 2 == 1) ? -16384 : 16383;
      5: return (k < N) ? 16383 : -16384;
      default: return (k < N) ? -16384 : 16383;
    endcase
  endfunction

  function automatic longint coef(int k);
    return longint'($signed(out_p[k*PW +: PW]));
  endfunction

  task automatic check(bit ok, string req, longint act, longint expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic build(int ma, int sa, int mb, int sb);
    for (int k = 0; k < FN; k++) begin
      ca[k] = gen(ma, sa, k);
      cb[k] = gen(mb, sb, k);
      in_a[k*CW +: CW] = 15'(ca[k]);
      in_b[k*CW +: CW] = 15'(cb[k]);
    end
    for (int k = 0; k < ON; k++) ex[k] = 0;
    for (int i = 0; i < FN; i++)
      for (int j = 0; j < FN; j++)
        ex[i+j] += longint'(ca[i]) * longint'(cb[j]);
  endtask

  // Offer operands at a negedge, take them at the next edge, scramble after (R9)
  task automatic send();
    @(negedge clk);
    check(in_ready == 1'b1, "R6 ready before send", longint'(in_ready), 1);
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    in_a = ~in_a;
    in_b = {in_b[FN*CW-2:0], ~in_b[FN*CW-1]};
  endtask

  // Called at the negedge after the accepting edge; counts edges to out_valid
  task automatic wait_out(output int edges);
    edges = 0;
    while (!out_valid && edges < 1000) begin
      @(posedge clk);
      edges++;
      @(negedge clk);
      if (edges == 5) check(in_ready == 1'b0, "R6 busy", longint'(in_ready), 0);
    end
  endtask

  task automatic compare(string req);
    for (int k = 0; k < ON; k++) check(coef(k) == ex[k], req, coef(k), ex[k]);
  endtask

  task automatic drain();
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    check(out_valid == 1'b0, "R5 single transfer", longint'(out_valid), 0);
    check(in_ready == 1'b1, "R6 idle after handoff", longint'(in_ready), 1);
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL R4 watchdog actual=%0d expected=%0d", 150000, 0);
    summary();
    $finish;
  end

  initial begin
    int e;
    logic [ON*PW-1:0] snap;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R8 reset out_valid", longint'(out_valid), 0);
    check(in_ready == 1'b1, "R8 reset in_ready", longint'(in_ready), 1);

    // Table walk: R1/R2 random, R3 extremes, R10 sparse after extremes
    for (int r = 0; r < NV; r++) begin
      build(TM_A[r], TS_A[r], TM_B[r], TS_B[r]);
      send();
      wait_out(e);
      check(e == LAT, "R4 latency", e, LAT);
      if (TM_A[r] == 3 || TM_B[r] == 3) compare("R10 sparse");
      else if (TM_A[r] == 0) compare("R1 R2 product");
      else compare("R3 extremes");
      drain();
    end

    // R5: back-pressure holds data; R9 already scrambled inputs during run
    build(0, 21, 0, 22);
    send();
    wait_out(e);
    snap = out_p;
    for (int t = 0; t < 4; t++) begin
      @(negedge clk);
      check(out_valid == 1'b1, "R5 valid held", longint'(out_valid), 1);
      check(out_p == snap, "R5 data held", 0, 0);
      check(in_ready == 1'b0, "R6 ready follows out_ready", longint'(in_ready), 0);
    end
    compare("R9 inputs ignored while busy");
    drain();

    // R7: handoff and new acceptance on the same edge
    build(0, 31, 0, 32);
    send();
    wait_out(e);
    compare("R7 first result");
    build(4, 0, 0, 33);
    out_ready = 1'b1;
    in_valid = 1'b1;
    #1;
    check(in_ready == 1'b1, "R7 ready on handoff", longint'(in_ready), 1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b0;
    check(out_valid == 1'b0, "R7 old result gone", longint'(out_valid), 0);
    check(in_ready == 1'b0, "R7 busy again", longint'(in_ready), 0);
    wait_out(e);
    check(e == LAT, "R7 latency", e, LAT);
    compare("R7 second result");
    drain();

    // R8: reset in the middle of a run
    build(0, 41, 0, 42);
    send();
    repeat (20) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R8 mid-run reset valid", longint'(out_valid), 0);
    check(in_ready == 1'b1, "R8 mid-run reset ready", longint'(in_ready), 1);
    rst_n = 1'b1;
    build(3, 2, 3, 3);
    send();
    wait_out(e);
    check(e == LAT, "R8 latency after reset", e, LAT);
    compare("R8 result after reset");
    drain();

    summary();
    $finish;
  end
endmodule